// File: doc/BRIEF.md
# Word Shifter with Status Flags

This block performs one of four shifts on a 16-bit word: arithmetic left, arithmetic right, logical right, and circular right. It also produces the status flags that such a shift affects. The surrounding datapath supplies a 2-bit operation code, the 4-bit count taken from the instruction, the operand, and the low four bits of general register 0. The block does not read registers or fetch instructions. Its caller holds those values on its inputs and raises a one-cycle valid strobe.

The shift amount is resolved before the shift. A non-zero count field is used as it is. A zero count field selects the low four bits of register 0 instead, and when those are also zero the amount is sixteen. A barrel network computes the shifted word in one combinational pass. The result and the flags are registered on the clock edge where the strobe is sampled. A completion pulse marks the cycle in which they become valid.

Top module: `shword_unit`

## Requirements
- R1: Operation code 2'b10 shifts left and fills the vacated low bits with zeros.
- R2: Operation code 2'b00 shifts right and fills the vacated high bits with copies of the operand's original bit 15.
- R3: Operation code 2'b01 shifts right and fills the vacated high bits with zeros.
- R4: Operation code 2'b11 rotates right, so each bit leaving bit 0 re-enters at bit 15. An amount of 16 returns the operand unchanged.
- R5: The shift amount is the count field when that field is non-zero. Otherwise it is the 4-bit register-0 value when that value is non-zero. Otherwise it is 16.
- R6: The carry flag equals the last bit shifted out: operand bit 16-n for the left shift, and operand bit n-1 for the right shifts.
- R7: For the left shift, overflow is set exactly when bit 15 takes a value different from its original value at any step of the shift.
- R8: For the three right shifts, the overflow flag keeps the value it had before the operation.
- R9: After each operation, the logical-greater flag is 1 when the result is non-zero. The arithmetic-greater flag is 1 when the result is positive as a signed number. The equal flag is 1 when the result is zero.
- R10: Result and flags update on the clock edge that samples the valid strobe, and `done_o` is high for exactly that following cycle. Without a strobe, result and flags hold their values.
- R11: After reset, the result, all five flags and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | One-cycle request strobe |
| op_i | input | 2 | Shift kind: 00 arith right, 01 logical right, 10 arith left, 11 circular right |
| cnt_field_i | input | 4 | Count from the instruction; 0 selects the register-0 count |
| r0_low_i | input | 4 | Low four bits of register 0 |
| operand_i | input | 16 | Word to shift |
| result_o | output | 16 | Registered shifted word |
| flag_lgt_o | output | 1 | Logical greater than zero |
| flag_agt_o | output | 1 | Arithmetic greater than zero |
| flag_eq_o | output | 1 | Result equals zero |
| flag_c_o | output | 1 | Carry, last bit shifted out |
| flag_ov_o | output | 1 | Overflow |
| done_o | output | 1 | High for the cycle after an accepted strobe |

## Verification
Every result and flag is due at the first rising edge after the strobe is sampled, which is one register stage of latency. `done_o` is high during the cycle that follows that edge. The bench drives each request on a falling edge and holds it through the next rising edge. It compares the outputs on the falling edge after that edge. It then checks them again after an idle cycle with different input values, to confirm that nothing moves without a strobe. The bench tracks the expected overflow value across operations. A right shift can then be checked against the overflow value left by the operation before it.

// File: rtl/shword_pkg.sv
package shword_pkg;
  typedef enum logic [1:0] {
    SH_ARITH_R = 2'b00,
    SH_LOGIC_R = 2'b01,
    SH_ARITH_L = 2'b10,
    SH_CIRC_R  = 2'b11
  } sh_op_e;

  typedef struct packed {
    logic lgt;
    logic agt;
    logic eq;
    logic c;
    logic ov;
  } sh_flags_t;
endpackage

// File: rtl/shword_count.sv
module shword_count #(
  parameter int CW = 4,
  localparam int AW = CW + 1
) (
  input  logic [CW-1:0] field_i,
  input  logic [CW-1:0] r0_i,
  output logic [AW-1:0] amount_o
);
  function automatic logic [AW-1:0] resolve(input logic [CW-1:0] f, input logic [CW-1:0] r);
    if (f != '0)      return {1'b0, f};
    else if (r != '0) return {1'b0, r};
    else              return AW'(1) << CW;
  endfunction

  assign amount_o = resolve(field_i, r0_i);
endmodule

// File: rtl/shword_barrel.sv
module shword_barrel
  import shword_pkg::*;
#(
  parameter int W = 16,
  localparam int AW = $clog2(W) + 1
) (
  input  sh_op_e         op_i,
  input  logic [W-1:0]   data_i,
  input  logic [AW-1:0]  amount_i,
  output logic [W-1:0]   data_o
);
  function automatic logic [W-1:0] stage_shift(input sh_op_e op, input logic [W-1:0] v,
                                               input logic sign, input int amt);
    logic [W-1:0] o;
    for (int i = 0; i < W; i++) begin
      case (op)
        SH_ARITH_L: o[i] = (i >= amt) ? v[(i - amt) % W] : 1'b0;
        SH_LOGIC_R: o[i] = (i + amt < W) ? v[(i + amt) % W] : 1'b0;
        SH_ARITH_R: o[i] = (i + amt < W) ? v[(i + amt) % W] : sign;
        default:    o[i] = v[(i + amt) % W];
      endcase
    end
    return o;
  endfunction

  logic [W-1:0] stg [AW+1];
  assign stg[0] = data_i;

  genvar k;
  generate
    for (k = 0; k < AW; k++) begin : g_stage
      assign stg[k+1] = amount_i[k] ? stage_shift(op_i, stg[k], data_i[W-1], 1 << k) : stg[k];
    end
  endgenerate

  assign data_o = stg[AW];
endmodule

// File: rtl/shword_flags.sv
module shword_flags
  import shword_pkg::*;
#(
  parameter int W = 16,
  localparam int AW = $clog2(W) + 1
) (
  input  sh_op_e        op_i,
  input  logic [W-1:0]  operand_i,
  input  logic [AW-1:0] amount_i,
  input  logic [W-1:0]  result_i,
  input  logic          ov_prev_i,
  output logic          carry_o,
  output logic          ovf_o,
  output sh_flags_t     flags_o
);
  function automatic logic last_out(input sh_op_e op, input logic [W-1:0] v, input int n);
    int idx;
    logic b;
    idx = (op == SH_ARITH_L) ? (W - n) : (n - 1);
    b = 1'b0;
    for (int i = 0; i < W; i++) if (i == idx) b = v[i];
    return b;
  endfunction

  function automatic logic msb_moved(input logic [W-1:0] v, input int n);
    logic m;
    logic bk;
    m = 1'b0;
    for (int k = 1; k <= W; k++) begin
      bk = (k < W) ? v[(W - 1 - k) % W] : 1'b0;
      if (k <= n && bk != v[W-1]) m = 1'b1;
    end
    return m;
  endfunction

  assign carry_o = last_out(op_i, operand_i, int'(amount_i));
  assign ovf_o   = (op_i == SH_ARITH_L) ? msb_moved(operand_i, int'(amount_i)) : ov_prev_i;

  always_comb begin
    flags_o.lgt = (result_i != '0);
    flags_o.agt = !result_i[W-1] && (result_i != '0);
    flags_o.eq  = (result_i == '0);
    flags_o.c   = carry_o;
    flags_o.ov  = ovf_o;
  end
endmodule

// File: rtl/shword_unit.sv
module shword_unit
  import shword_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [1:0]    op_i,
  input  logic [CW-1:0] cnt_field_i,
  input  logic [CW-1:0] r0_low_i,
  input  logic [W-1:0]  operand_i,
  output logic [W-1:0]  result_o,
  output logic          flag_lgt_o,
  output logic          flag_agt_o,
  output logic          flag_eq_o,
  output logic          flag_c_o,
  output logic          flag_ov_o,
  output logic          done_o
);
  localparam int AW = CW + 1;

  sh_op_e        op_e;
  logic [AW-1:0] eff_cnt;
  logic [W-1:0]  comb_result;
  logic          comb_carry;
  logic          comb_ovf;
  sh_flags_t     comb_flags;
  sh_flags_t     flags_q;
  logic [W-1:0]  result_q;
  logic          done_q;

  assign op_e = sh_op_e'(op_i);

  shword_count #(.CW(CW)) u_count (
    .field_i (cnt_field_i),
    .r0_i    (r0_low_i),
    .amount_o(eff_cnt)
  );

  shword_barrel #(.W(W)) u_barrel (
    .op_i    (op_e),
    .data_i  (operand_i),
    .amount_i(eff_cnt),
    .data_o  (comb_result)
  );

  shword_flags #(.W(W)) u_flags (
    .op_i     (op_e),
    .operand_i(operand_i),
    .amount_i (eff_cnt),
    .result_i (comb_result),
    .ov_prev_i(flags_q.ov),
    .carry_o  (comb_carry),
    .ovf_o    (comb_ovf),
    .flags_o  (comb_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flags_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        result_q <= comb_result;
        flags_q  <= comb_flags;
      end
    end
  end

  assign result_o   = result_q;
  assign flag_lgt_o = flags_q.lgt;
  assign flag_agt_o = flags_q.agt;
  assign flag_eq_o  = flags_q.eq;
  assign flag_c_o   = flags_q.c;
  assign flag_ov_o  = flags_q.ov;
  assign done_o     = done_q;
endmodule

// File: rtl/shword_unit_chk.sv
module shword_unit_chk #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_i,
  input logic [1:0]    op_i,
  input logic [CW-1:0] cnt_field_i,
  input logic [CW-1:0] r0_low_i,
  input logic [W-1:0]  operand_i,
  input logic [CW:0]   eff_cnt,
  input logic [W-1:0]  result_o,
  input logic          flag_lgt_o,
  input logic          flag_eq_o,
  input logic          flag_c_o,
  input logic          flag_ov_o,
  input logic          done_o
);
  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_field_i == '0 && r0_low_i == '0) |-> eff_cnt == (CW+1)'(W));

  assert_rot_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b11 && eff_cnt == (CW+1)'(W)) |=> result_o == $past(operand_i));

  assert_rot_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b11) |=> flag_c_o == result_o[W-1]);

  assert_ov_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 2'b10) |=> flag_ov_o == $past(flag_ov_o));

  assert_zero_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_eq_o == (result_o == '0)) && (flag_lgt_o != flag_eq_o));

  assert_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o) && !done_o);
endmodule

bind shword_unit shword_unit_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
  .cnt_field_i(cnt_field_i), .r0_low_i(r0_low_i), .operand_i(operand_i),
  .eff_cnt(eff_cnt), .result_o(result_o), .flag_lgt_o(flag_lgt_o),
  .flag_eq_o(flag_eq_o), .flag_c_o(flag_c_o), .flag_ov_o(flag_ov_o),
  .done_o(done_o)
);

// File: tb/shword_unit_tb.sv
module shword_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [3:0]  cnt_field_i = '0;
  logic [3:0]  r0_low_i = '0;
  logic [15:0] operand_i = '0;
  logic [15:0] result_o;
  logic        flag_lgt_o, flag_agt_o, flag_eq_o, flag_c_o, flag_ov_o, done_o;

  int checks = 0;
  int fails  = 0;
  logic model_ov = 1'b0;

  always #5 clk = ~clk;

  shword_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .cnt_field_i(cnt_field_i), .r0_low_i(r0_low_i), .operand_i(operand_i),
    .result_o(result_o), .flag_lgt_o(flag_lgt_o), .flag_agt_o(flag_agt_o),
    .flag_eq_o(flag_eq_o), .flag_c_o(flag_c_o), .flag_ov_o(flag_ov_o),
    .done_o(done_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Step-by-step reference: one bit per iteration
  function automatic int amount(input logic [3:0] f, input logic [3:0] r);
    if (f != 0) return int'(f);
    if (r != 0) return int'(r);
    return 16;
  endfunction

  task automatic apply(input logic [1:0] op, input logic [3:0] f, input logic [3:0] r,
                       input logic [15:0] v);
    logic [15:0] w;
    logic c, ov, m0;
    string rtag;
    int n;
    n = amount(f, r);
    w = v; c = 1'b0; ov = 1'b0; m0 = v[15];
    for (int s = 0; s < n; s++) begin
      case (op)
        2'b10: begin c = w[15]; w = {w[14:0], 1'b0}; if (w[15] != m0) ov = 1'b1; end
        2'b00: begin c = w[0]; w = {v[15], w[15:1]}; end
        2'b01: begin c = w[0]; w = {1'b0, w[15:1]}; end
        default: begin c = w[0]; w = {w[0], w[15:1]}; end
      endcase
    end
    if (op == 2'b10) model_ov = ov;
    case (op)
      2'b10: rtag = "R1";
      2'b00: rtag = "R2";
      2'b01: rtag = "R3";
      default: rtag = "R4";
    endcase
    @(negedge clk);
    valid_i = 1'b1; op_i = op; cnt_field_i = f; r0_low_i = r; operand_i = v;
    @(negedge clk);
    valid_i = 1'b0;
    check({rtag, (f == 0) ? " R5 result" : " result"}, result_o, w);
    check("R6 carry", {15'd0, flag_c_o}, {15'd0, c});
    check((op == 2'b10) ? "R7 overflow" : "R8 overflow", {15'd0, flag_ov_o}, {15'd0, model_ov});
    check("R9 flags", {13'd0, flag_lgt_o, flag_agt_o, flag_eq_o},
          {13'd0, w != 0, !w[15] && w != 0, w == 0});
    check("R10 done", {15'd0, done_o}, 16'd1);
    // idle cycle with disturbed inputs: nothing may move
    op_i = ~op; operand_i = ~v; cnt_field_i = f + 4'd1;
    @(negedge clk);
    check("R10 hold", result_o, w);
    check("R10 done low", {15'd0, done_o}, 16'd0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R11 reset result", result_o, 16'h0000);
    check("R11 reset flags", {10'd0, flag_lgt_o, flag_agt_o, flag_eq_o, flag_c_o, flag_ov_o, done_o}, 16'd0);
    rst_n = 1'b1;
    // directed corners
    apply(2'b10, 4'd1, 4'd0, 16'h4000);   // R7 MSB flips
    apply(2'b00, 4'd3, 4'd0, 16'h8001);   // R2 sign fill, R8 keep ov=1
    apply(2'b10, 4'd2, 4'd0, 16'h0003);   // R7 no flip -> 0
    apply(2'b01, 4'd4, 4'd0, 16'hF00F);   // R3
    apply(2'b11, 4'd0, 4'd0, 16'hA5C3);   // R4 R5 amount 16
    apply(2'b11, 4'd0, 4'd5, 16'h1234);   // R5 from register 0
    apply(2'b10, 4'd0, 4'd0, 16'h8001);   // R5 R6 left by 16
    apply(2'b01, 4'd0, 4'd0, 16'h8000);   // R3 to zero, R9 eq
    apply(2'b00, 4'd0, 4'd0, 16'h8000);   // R2 all ones
    apply(2'b10, 4'd15, 4'd9, 16'h0001);  // R1 into MSB
    for (int i = 0; i < 300; i++)
      apply(2'($urandom()), 4'($urandom()), 4'($urandom() % 3 == 0 ? 0 : $urandom()), 16'($urandom()));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule